// File: doc/BRIEF.md
# Two-Word Instruction Prefetch Queue

This block is the instruction fetch front end of a 16-bit processor. It keeps up to two prefetched instruction words ready for the execute stage and exposes them as a head word and a second word, together with a count of how many are valid. The execute stage removes one word for a short instruction or two words for a long one. The queue refills itself one word per cycle over a single external bus. That bus is shared with the operand reads and writes that the execute stage requests.

The bus has a single-cycle read path. In a cycle where the block drives an address with the read strobe, the word on `bus_rdata` is captured at the next clock edge. A fetch is issued in every cycle in which the queue would otherwise end the cycle below two words, so an instruction that works only on registers overlaps with its refill read. An operand access waits until the queue is full and no pop is taking place, and it is granted in that cycle. On a flush (reset vector, taken branch or jump, interrupt return), the block empties the queue and reloads the fetch counter with the target. It then spends the following two cycles refilling from the target.

Top module: `ifq_front`

## Requirements
- R1: While `rst` is high, `q_count` reads 0 and no bus strobe or grant is driven. The first two cycles after reset fetch from `RESET_PC` and `RESET_PC`+1.
- R2: A fetch (`bus_rd` high with the fetch counter on `bus_addr`) is issued in every cycle without reset or flush in which `q_count` is below 2 or an accepted pop occurs. Each fetch advances the counter by exactly one.
- R3: An accepted one-word pop (`pop`=1, `pop_two`=0) moves the second word to the head. A word fetched in the same cycle lands behind it.
- R4: An accepted two-word pop (`pop_two`=1) discards both words. A word fetched in the same cycle becomes the only valid word, at the head.
- R5: While `flush` is high, neither bus strobe nor `dgrant` is driven. `q_count` is 0 in the next cycle, and the next fetch reads from `flush_pc`.
- R6: A granted write (`dwe`=1) drives `bus_wr` high, `bus_addr`=`daddr` and `bus_wdata`=`dwdata`, with `dgrant` high in that same cycle.
- R7: A granted read (`dwe`=0) drives `bus_rd` high with `bus_addr`=`daddr` and returns `bus_rdata` on `drdata` in the grant cycle. The read does not enter the queue.
- R8: A pop that asks for more words than `q_count` holds is ignored: the queue contents and count are unchanged by it.
- R9: `q_count` never exceeds 2. `bus_rd` and `bus_wr` are never high together.
- R10: A data request is granted only in a cycle with no fetch, that is, when `q_count` is 2 and no pop is accepted. Otherwise it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue and redirect fetching |
| flush_pc | input | AW | Redirect target word address |
| pop | input | 1 | Execute stage consumes an instruction |
| pop_two | input | 1 | Length flag: 1 = two words, 0 = one word |
| q_count | output | 2 | Number of valid queued words (0..2) |
| q_head | output | DW | Oldest queued word |
| q_next | output | DW | Second queued word |
| dreq | input | 1 | Operand access request |
| dwe | input | 1 | Operand access is a write |
| daddr | input | AW | Operand address |
| dwdata | input | DW | Operand write data |
| dgrant | output | 1 | Operand access performed this cycle |
| drdata | output | DW | Operand read data, valid with a read grant |
| bus_addr | output | AW | External bus address |
| bus_rd | output | 1 | External read strobe |
| bus_wr | output | 1 | External write strobe |
| bus_wdata | output | DW | External write data |
| bus_rdata | input | DW | External read data, same cycle |

## Verification
A refill fetch and a pending operand request can fall in the same cycle. The bench provokes this by raising `dreq` right after a pop, or together with a pop, while the queue is short. It judges the outcome by checking that the grant is withheld and that the bus carries the fetch address until the queue is full again. A flush can also coincide with a pop and a request. The bench checks that nothing reaches the bus in that cycle and that the next read comes from the target. A replay of a short mixed program checks the exact address and grant sequence, and seeded random traffic is compared cycle by cycle against a bench model.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    typedef logic [1:0] qcnt_t;

    localparam qcnt_t QFULL = 2'd2;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_FETCH  = 2'd1,
        BUS_DREAD  = 2'd2,
        BUS_DWRITE = 2'd3
    } bus_op_e;

    // Words removed by an instruction of the given length flag.
    function automatic qcnt_t words_for(input logic two);
        return two ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/ifq_arbiter.sv
module ifq_arbiter
    import ifq_pkg::*;
(
    input  logic    rst,
    input  logic    flush,
    input  qcnt_t   q_count,
    input  logic    pop_ok,
    input  logic    dreq,
    input  logic    dwe,
    output logic    fetch_go,
    output logic    grant,
    output bus_op_e bus_op
);

    logic live;

    always_comb begin
        live     = !rst && !flush;
        // Refill wins whenever the queue would end the cycle short.
        fetch_go = live && ((q_count < QFULL) || pop_ok);
        grant    = live && dreq && !fetch_go;
        if (fetch_go)
            bus_op = BUS_FETCH;
        else if (grant)
            bus_op = dwe ? BUS_DWRITE : BUS_DREAD;
        else
            bus_op = BUS_IDLE;
    end

endmodule

// File: rtl/ifq_pc.sv
module ifq_pc #(
    parameter int              AW       = 16,
    parameter logic [AW-1:0]   RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] flush_pc,
    input  logic          advance,
    output logic [AW-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_PC;
        else if (flush)
            pc <= flush_pc;
        else if (advance)
            pc <= pc + AW'(1);
    end

endmodule

// File: rtl/ifq_queue.sv
module ifq_queue
    import ifq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  qcnt_t         take,
    input  logic          push,
    input  logic [DW-1:0] push_word,
    output qcnt_t         count,
    output logic [DW-1:0] head,
    output logic [DW-1:0] second
);

    qcnt_t         left;
    qcnt_t         count_n;
    logic [DW-1:0] head_n;
    logic [DW-1:0] second_n;

    always_comb begin
        left     = count - take;
        head_n   = head;
        second_n = second;
        if (take == 2'd1)
            head_n = second;
        if (push) begin
            if (left == 2'd0)
                head_n = push_word;
            else
                second_n = push_word;
        end
        count_n = left + qcnt_t'(push);
    end

    always_ff @(posedge clk) begin
        if (rst || flush)
            count <= '0;
        else
            count <= count_n;
        head   <= head_n;
        second <= second_n;
    end

endmodule

// File: rtl/ifq_front.sv
module ifq_front
    import ifq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] flush_pc,
    input  logic          pop,
    input  logic          pop_two,
    output logic [1:0]    q_count,
    output logic [DW-1:0] q_head,
    output logic [DW-1:0] q_next,
    input  logic          dreq,
    input  logic          dwe,
    input  logic [AW-1:0] daddr,
    input  logic [DW-1:0] dwdata,
    output logic          dgrant,
    output logic [DW-1:0] drdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);

    qcnt_t         count;
    qcnt_t         need;
    qcnt_t         take;
    logic          pop_ok;
    logic          fetch_go;
    bus_op_e       bus_op;
    logic [AW-1:0] pc;

    always_comb begin
        need   = words_for(pop_two);
        pop_ok = pop && (count >= need);
        take   = pop_ok ? need : '0;
    end

    ifq_arbiter u_arb (
        .rst      (rst),
        .flush    (flush),
        .q_count  (count),
        .pop_ok   (pop_ok),
        .dreq     (dreq),
        .dwe      (dwe),
        .fetch_go (fetch_go),
        .grant    (dgrant),
        .bus_op   (bus_op)
    );

    ifq_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .flush_pc (flush_pc),
        .advance  (fetch_go),
        .pc       (pc)
    );

    ifq_queue #(.DW(DW)) u_q (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .take      (take),
        .push      (fetch_go),
        .push_word (bus_rdata),
        .count     (count),
        .head      (q_head),
        .second    (q_next)
    );

    always_comb begin
        bus_rd    = (bus_op == BUS_FETCH) || (bus_op == BUS_DREAD);
        bus_wr    = (bus_op == BUS_DWRITE);
        bus_wdata = bus_wr ? dwdata : '0;
        case (bus_op)
            BUS_FETCH:              bus_addr = pc;
            BUS_DREAD, BUS_DWRITE:  bus_addr = daddr;
            default:                bus_addr = '0;
        endcase
        drdata  = bus_rdata;
        q_count = count;
    end

endmodule

// File: rtl/ifq_front_chk.sv
module ifq_front_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic [AW-1:0] flush_pc,
    input logic          pop,
    input logic [1:0]    q_count,
    input logic          dreq,
    input logic          dwe,
    input logic [AW-1:0] daddr,
    input logic [DW-1:0] dwdata,
    input logic          dgrant,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata
);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        q_count <= 2'd2);

    p_strobes_apart_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    p_fill_when_short_r2: assert property (@(posedge clk) disable iff (rst)
        (!flush && q_count < 2'd2) |-> (bus_rd && !dgrant));

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd && !dgrant) ##1 (bus_rd && !dgrant))
            |-> bus_addr == $past(bus_addr) + AW'(1));

    p_flush_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!bus_rd && !bus_wr && !dgrant));

    p_flush_empties_r5: assert property (@(posedge clk) disable iff (rst)
        flush |=> q_count == 2'd0);

    p_flush_target_r5: assert property (@(posedge clk) disable iff (rst)
        flush |=> (flush || (bus_rd && bus_addr == $past(flush_pc))));

    p_grant_when_full_r10: assert property (@(posedge clk) disable iff (rst)
        dgrant |-> (dreq && q_count == 2'd2 && !pop));

    p_write_path_r6: assert property (@(posedge clk) disable iff (rst)
        (dgrant && dwe) |-> (bus_wr && bus_addr == daddr && bus_wdata == dwdata));

endmodule

bind ifq_front ifq_front_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .flush_pc  (flush_pc),
    .pop       (pop),
    .q_count   (q_count),
    .dreq      (dreq),
    .dwe       (dwe),
    .daddr     (daddr),
    .dwdata    (dwdata),
    .dgrant    (dgrant),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata)
);

// File: tb/ifq_front_tb.sv
module ifq_front_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst, flush, pop, pop_two, dreq, dwe;
    logic [15:0] flush_pc, daddr, dwdata;
    logic [1:0]  q_count;
    logic [15:0] q_head, q_next, drdata, bus_addr, bus_wdata, bus_rdata;
    logic        dgrant, bus_rd, bus_wr;

    int tests = 0;
    int fails = 0;

    // bench model state
    int          m_cnt;
    logic [15:0] m_w0, m_w1, m_pc;
    logic [15:0] last_addr;
    logic        last_rd, last_wr, last_gnt;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return (a * 16'h3B1D) ^ 16'hC6A5;
    endfunction

    assign bus_rdata = memf(bus_addr);

    ifq_front u_dut (
        .clk(clk), .rst(rst), .flush(flush), .flush_pc(flush_pc),
        .pop(pop), .pop_two(pop_two), .q_count(q_count), .q_head(q_head),
        .q_next(q_next), .dreq(dreq), .dwe(dwe), .daddr(daddr),
        .dwdata(dwdata), .dgrant(dgrant), .drdata(drdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the current cycle against the model, then advance the model.
    task automatic judge();
        int need, take, left;
        bit acc, fet, gnt;
        need = pop_two ? 2 : 1;
        acc  = !rst && !flush && pop && (m_cnt >= need);
        take = acc ? need : 0;
        fet  = !rst && !flush && (m_cnt < 2 || acc);
        gnt  = !rst && !flush && dreq && !fet;

        if (rst) check(q_count == 2'd0, "R1 count in reset", 32'(q_count), 0);
        else     check(32'(q_count) == 32'(m_cnt), "R9 q_count", 32'(q_count), 32'(m_cnt));
        if (m_cnt >= 1) check(q_head == m_w0, "R3 head word", 32'(q_head), 32'(m_w0));
        if (m_cnt == 2) check(q_next == m_w1, "R4 second word", 32'(q_next), 32'(m_w1));
        check(dgrant == gnt, "R10 grant", 32'(dgrant), 32'(gnt));
        check(bus_rd == (fet || (gnt && !dwe)), "R2 read strobe", 32'(bus_rd),
              32'(fet || (gnt && !dwe)));
        check(bus_wr == (gnt && dwe), "R6 write strobe", 32'(bus_wr), 32'(gnt && dwe));
        if (fet) check(bus_addr == m_pc, "R2 fetch address", 32'(bus_addr), 32'(m_pc));
        if (gnt) check(bus_addr == daddr, "R6 data address", 32'(bus_addr), 32'(daddr));
        if (gnt && dwe)  check(bus_wdata == dwdata, "R6 write data", 32'(bus_wdata), 32'(dwdata));
        if (gnt && !dwe) check(drdata == memf(daddr), "R7 read data", 32'(drdata), 32'(memf(daddr)));

        last_addr = bus_addr; last_rd = bus_rd; last_wr = bus_wr; last_gnt = dgrant;

        if (rst) begin
            m_cnt = 0; m_pc = 16'h0000;
        end else if (flush) begin
            m_cnt = 0; m_pc = flush_pc;
        end else begin
            left = m_cnt - take;
            if (take == 1) m_w0 = m_w1;
            if (fet) begin
                if (left == 0) m_w0 = memf(m_pc);
                else           m_w1 = memf(m_pc);
                m_pc = m_pc + 16'd1;
            end
            m_cnt = left + (fet ? 1 : 0);
        end
    endtask

    task automatic cyc(input logic p, input logic t, input logic dr, input logic we,
                       input logic [15:0] da);
        pop = p; pop_two = t; dreq = dr; dwe = we; daddr = da;
        dwdata = da ^ 16'h1234;
        @(negedge clk);
        judge();
        @(posedge clk);
        #1;
        flush = 1'b0;
    endtask

    task automatic do_flush(input logic [15:0] tgt, input logic p, input logic dr);
        flush = 1'b1; flush_pc = tgt;
        cyc(p, 1'b0, dr, 1'b0, 16'h0042);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] exp_addr [9];
        logic        exp_gnt  [9];
        rst = 1'b1; flush = 1'b0; flush_pc = '0; pop = 0; pop_two = 0;
        dreq = 0; dwe = 0; daddr = '0; dwdata = '0;
        m_cnt = 0; m_pc = '0; m_w0 = '0; m_w1 = '0;
        @(posedge clk); #1;
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        rst = 1'b0;

        // Mixed program replay: short, long, long+store, short.
        exp_addr = '{16'h0, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5, 16'h6, 16'h4000, 16'h7};
        exp_gnt  = '{0, 0, 0, 0, 0, 0, 0, 1, 0};
        for (int i = 0; i < 9; i++) begin
            case (i)
                2:       cyc(1, 0, 0, 0, 16'h0);
                3:       cyc(1, 1, 0, 0, 16'h0);
                5:       cyc(1, 1, 1, 1, 16'h4000);
                6, 7:    cyc(0, 0, 1, 1, 16'h4000);
                8:       cyc(1, 0, 0, 0, 16'h0);
                default: cyc(0, 0, 0, 0, 16'h0);
            endcase
            check(last_addr == exp_addr[i], i < 2 ? "R1 start address" : "R2 program address",
                  32'(last_addr), 32'(exp_addr[i]));
            check(last_gnt == exp_gnt[i], "R10 program grant pattern",
                  32'(last_gnt), 32'(exp_gnt[i]));
        end

        // Flush together with a pop and a data request.
        do_flush(16'h0100, 1'b1, 1'b1);
        check(!last_rd && !last_wr && !last_gnt, "R5 quiet flush cycle",
              {29'd0, last_rd, last_wr, last_gnt}, 0);
        // Two-word pop while empty, then while one word is valid: both ignored.
        cyc(1, 1, 0, 0, 0);
        check(last_addr == 16'h0100, "R5 target fetch", 32'(last_addr), 32'h0100);
        cyc(1, 1, 0, 0, 0);
        check(q_count == 2'd2, "R8 ignored over-pop", 32'(q_count), 2);
        check(q_head == memf(16'h0100), "R8 head kept", 32'(q_head), 32'(memf(16'h0100)));
        // Operand read when full.
        cyc(0, 0, 1, 0, 16'h0BEE);
        check(last_gnt && last_rd, "R7 read granted", {30'd0, last_gnt, last_rd}, 3);
        // Request alongside a one-word pop: fetch wins.
        cyc(1, 0, 1, 0, 16'h0BEF);
        check(!last_gnt, "R10 request held behind refill", 32'(last_gnt), 0);

        // Seeded random traffic.
        void'($urandom(32'd4711));
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 40) == 0) begin
                flush = 1'b1;
                flush_pc = 16'($urandom);
            end
            cyc(1'(($urandom % 3) != 0), 1'($urandom), 1'(($urandom % 4) == 0),
                1'($urandom), 16'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule